// File: doc/BRIEF.md
# Host Controller Command and Interrupt Register Bank

This block holds the byte-wide control and status registers of a USB host controller. A bus master reaches it through a 12-bit byte offset. Each write carries one data byte. Each read returns one byte, decoded from the offset in the same cycle. Every byte lane has its own write behaviour. Some lanes are plain storage. Some keep only a masked subset of the written bits. Some clear the bits that are written as one, and some ignore writes altogether.

Two command bytes have side effects beyond their own storage:

- **Command/status byte.** It can restore the whole bank to its power-up image. It can also post an ownership-change request, which raises a one-cycle system-management interrupt when both enable bits of that interrupt are set.
- **Control byte.** When it is written with the bus-reset state, it loads a fixed change pattern into the change-status bytes of both root hub ports. It also emits a one-cycle strobe, so that a companion root hub block can follow.

Storage is implemented for offsets below `STORE_BYTES` (default 128). Offsets at or above that value read as zero and take no writes.

Top module: `ohc_regbank`

## Requirements
- R1: After synchronous reset, offset 0x00 reads 0x10, offset 0x01 reads 0x01, offset 0x48 reads 0x02, and every other offset from 0x000 to 0xFFF reads 0x00.
- R2: Offsets at or above `STORE_BYTES` (default 128) always read 0x00, and writes to them change nothing.
- R3: A byte without a special rule stores the written value. `rd_data` shows the byte at `addr` combinationally, so the new value is visible from the clock edge that took the write.
- R4: Writing offset 0x08 with bit 0 set restores the whole bank to the R1 image. Offset 0x08 then holds the written value with bit 0 cleared. A reset in the same write overrides the R5 flag.
- R5: Writing offset 0x08 with bit 3 set (and bit 0 clear) sets bit 6 of offset 0x0F. Other bits of 0x08 are stored as written.
- R6: `smi_pulse` is high for exactly the one cycle after the clock edge of a write to 0x08 with bit 3 set, and only if bits 7 and 6 of offset 0x13 are both 1 at that write.
- R7: Offset 0x0C clears each bit written as 1 within mask 0x7F and never changes bit 7. Offset 0x0F clears only bit 6, and only when bit 6 is written as 1.
- R8: Writes to offsets 0x0D, 0x0E, 0x18 to 0x1B, 0x3A, 0x3E, 0x3F, 0x42, 0x43, 0x46 and 0x47 leave those bytes unchanged.
- R9: Masked lanes keep only part of the written value: 0x3B keeps bit 7, 0x39 and 0x41 keep bits 5:0, and 0x45 keeps bits 3:0. All other bits read 0.
- R10: Offset 0x04 stores the written value. When bits 7:6 of that value are 00, offsets 0x56 and 0x5A are loaded with 0x16, and `port_chg_strobe` is high for the one cycle after the write edge. Any other value of bits 7:6 loads nothing and leaves the strobe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 12 | Byte offset for both read and write |
| wr_en | input | 1 | Write strobe, taken on the rising clock edge |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Byte at `addr`, combinational |
| smi_pulse | output | 1 | One-cycle system-management interrupt pulse |
| port_chg_strobe | output | 1 | One-cycle strobe for the root hub on a bus-reset write |

## Verification
The bench sweeps every offset, both after reset and after a write. This exposes any lane that is given the wrong mask, or that stores a value where it should ignore or clear it. A decoder that mixes up neighbouring offsets (0x39 and 0x3A, or 0x0C and 0x0D) would show the wrong value at one of them.

The command byte is driven with ownership and reset bits alone and then together:

- An interrupt that ignores one of the two enable bits would pulse when it should not.
- A reset that fails to win over the ownership flag would leave 0x0F nonzero.
- A reset that does not strip bit 0 would leave it readable in 0x08.

The control byte is written with both a bus-reset value and a non-reset value. A wrong test of bits 7:6 would either load the port change bytes spuriously or miss the strobe.

// File: rtl/ohc_pkg.sv
package ohc_pkg;

    typedef enum logic [2:0] {
        WR_PLAIN,
        WR_IGNORE,
        WR_MASKED,
        WR_W1C,
        WR_CMD,
        WR_CTRL
    } wr_kind_e;

    typedef struct packed {
        wr_kind_e   kind;
        logic [7:0] mask;
    } wr_rule_t;

    localparam logic [11:0] OFS_CTRL    = 12'h004;
    localparam logic [11:0] OFS_CMD     = 12'h008;
    localparam logic [11:0] OFS_IRQ_ST3 = 12'h00F;
    localparam logic [11:0] OFS_IRQ_EN3 = 12'h013;
    localparam logic [11:0] OFS_P1_CHG  = 12'h056;
    localparam logic [11:0] OFS_P2_CHG  = 12'h05A;

    localparam logic [7:0] BUS_RST_CHG  = 8'h16;
    localparam logic [7:0] OWN_FLAG     = 8'h40;

    // power-up content of one byte lane
    function automatic logic [7:0] default_byte(input logic [11:0] ofs);
        case (ofs)
            12'h000: default_byte = 8'h10;
            12'h001: default_byte = 8'h01;
            12'h048: default_byte = 8'h02;
            default: default_byte = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/ohc_rule_dec.sv
module ohc_rule_dec
    import ohc_pkg::*;
(
    input  logic [11:0] ofs,
    output wr_rule_t    rule
);

    always_comb begin
        rule = '{kind: WR_PLAIN, mask: 8'hFF};
        case (ofs)
            OFS_CTRL:                       rule = '{kind: WR_CTRL,   mask: 8'hFF};
            OFS_CMD:                        rule = '{kind: WR_CMD,    mask: 8'hFF};
            12'h00C:                        rule = '{kind: WR_W1C,    mask: 8'h7F};
            OFS_IRQ_ST3:                    rule = '{kind: WR_W1C,    mask: 8'h40};
            12'h00D, 12'h00E,
            12'h018, 12'h019, 12'h01A, 12'h01B,
            12'h03A, 12'h03E, 12'h03F,
            12'h042, 12'h043,
            12'h046, 12'h047:               rule = '{kind: WR_IGNORE, mask: 8'h00};
            12'h039, 12'h041:               rule = '{kind: WR_MASKED, mask: 8'h3F};
            12'h03B:                        rule = '{kind: WR_MASKED, mask: 8'h80};
            12'h045:                        rule = '{kind: WR_MASKED, mask: 8'h0F};
            default:                        rule = '{kind: WR_PLAIN,  mask: 8'hFF};
        endcase
    end

endmodule

// File: rtl/ohc_cmd_eval.sv
module ohc_cmd_eval (
    input  logic       hit_cmd,
    input  logic       hit_ctrl,
    input  logic [7:0] wr_data,
    input  logic [7:0] irq_en_hi,
    output logic       soft_rst,
    output logic       own_req,
    output logic       smi_fire,
    output logic       bus_rst
);

    always_comb begin
        soft_rst = hit_cmd && wr_data[0];
        own_req  = hit_cmd && wr_data[3];
        smi_fire = own_req && (irq_en_hi[7:6] == 2'b11);
        bus_rst  = hit_ctrl && (wr_data[7:6] == 2'b00);
    end

endmodule

// File: rtl/ohc_regbank.sv
module ohc_regbank
    import ohc_pkg::*;
#(
    parameter int STORE_BYTES = 128
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [11:0] addr,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    output logic [7:0]  rd_data,
    output logic        smi_pulse,
    output logic        port_chg_strobe
);

    localparam int IDX_W = $clog2(STORE_BYTES);

    typedef logic [STORE_BYTES-1:0][7:0] image_t;

    typedef struct packed {
        image_t mem;
        logic   smi;
        logic   chg;
    } state_t;

    function automatic image_t reset_image();
        image_t img;
        for (int i = 0; i < STORE_BYTES; i++) begin
            img[i] = default_byte(12'(i));
        end
        return img;
    endfunction

    localparam image_t RESET_IMG = reset_image();

    state_t             st_d, st_q;
    wr_rule_t           rule;
    logic               in_range;
    logic [IDX_W-1:0]   idx;
    logic               soft_rst, own_req, smi_fire, bus_rst;

    assign in_range = (addr < 12'(STORE_BYTES));
    assign idx      = addr[IDX_W-1:0];

    ohc_rule_dec u_dec (
        .ofs  (addr),
        .rule (rule)
    );

    ohc_cmd_eval u_cmd (
        .hit_cmd   (wr_en && in_range && (rule.kind == WR_CMD)),
        .hit_ctrl  (wr_en && in_range && (rule.kind == WR_CTRL)),
        .wr_data   (wr_data),
        .irq_en_hi (st_q.mem[OFS_IRQ_EN3[IDX_W-1:0]]),
        .soft_rst  (soft_rst),
        .own_req   (own_req),
        .smi_fire  (smi_fire),
        .bus_rst   (bus_rst)
    );

    always_comb begin
        st_d     = st_q;
        st_d.smi = 1'b0;
        st_d.chg = 1'b0;
        if (wr_en && in_range) begin
            case (rule.kind)
                WR_PLAIN:  st_d.mem[idx] = wr_data;
                WR_MASKED: st_d.mem[idx] = wr_data & rule.mask;
                WR_W1C:    st_d.mem[idx] = st_q.mem[idx] & ~(wr_data & rule.mask);
                WR_CTRL: begin
                    st_d.mem[idx] = wr_data;
                    if (bus_rst) begin
                        st_d.mem[OFS_P1_CHG[IDX_W-1:0]] = BUS_RST_CHG;
                        st_d.mem[OFS_P2_CHG[IDX_W-1:0]] = BUS_RST_CHG;
                        st_d.chg = 1'b1;
                    end
                end
                WR_CMD: begin
                    st_d.smi = smi_fire;
                    if (soft_rst) begin
                        st_d.mem      = RESET_IMG;
                        st_d.mem[idx] = wr_data & 8'hFE;
                    end else begin
                        st_d.mem[idx] = wr_data;
                        if (own_req) begin
                            st_d.mem[OFS_IRQ_ST3[IDX_W-1:0]] =
                                st_q.mem[OFS_IRQ_ST3[IDX_W-1:0]] | OWN_FLAG;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{mem: RESET_IMG, smi: 1'b0, chg: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data         = in_range ? st_q.mem[idx] : 8'h00;
    assign smi_pulse       = st_q.smi;
    assign port_chg_strobe = st_q.chg;

endmodule

// File: rtl/ohc_regbank_chk.sv
module ohc_regbank_chk #(
    parameter int STORE_BYTES = 128
) (
    input logic        clk,
    input logic        rst,
    input logic [11:0] addr,
    input logic        wr_en,
    input logic [7:0]  wr_data,
    input logic [7:0]  rd_data,
    input logic        smi_pulse,
    input logic        port_chg_strobe
);

    // R6
    smi_cause_chk: assert property (@(posedge clk) disable iff (rst)
        smi_pulse |-> $past(wr_en && addr == 12'h008 && wr_data[3]));

    // R10
    chg_cause_chk: assert property (@(posedge clk) disable iff (rst)
        port_chg_strobe |-> $past(wr_en && addr == 12'h004 && wr_data[7:6] == 2'b00));

    // R1
    rev_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && addr == 12'h000) |-> rd_data == 8'h10);

    // R7
    w1c_low_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 12'h00C && wr_data[0]) |=> (addr != 12'h00C || !rd_data[0]));

    // R8
    ignore_lane_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 12'h00D) |=> (addr != 12'h00D || $stable(rd_data)));

    // R2
    beyond_store_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr >= 12'(STORE_BYTES)) |=> (addr != $past(addr) || rd_data == 8'h00));

endmodule

bind ohc_regbank ohc_regbank_chk #(.STORE_BYTES(STORE_BYTES)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .addr            (addr),
    .wr_en           (wr_en),
    .wr_data         (wr_data),
    .rd_data         (rd_data),
    .smi_pulse       (smi_pulse),
    .port_chg_strobe (port_chg_strobe)
);

// File: tb/ohc_regbank_tb.sv
module ohc_regbank_tb;

    localparam int CLK_PERIOD = 10;
    localparam int STORE = 128;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] addr = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic        smi_pulse;
    logic        port_chg_strobe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ohc_regbank #(.STORE_BYTES(STORE)) u_dut (
        .clk             (clk),
        .rst             (rst),
        .addr            (addr),
        .wr_en           (wr_en),
        .wr_data         (wr_data),
        .rd_data         (rd_data),
        .smi_pulse       (smi_pulse),
        .port_chg_strobe (port_chg_strobe)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] dflt(input int ofs);
        if (ofs == 0) return 8'h10;
        if (ofs == 1) return 8'h01;
        if (ofs == 'h48) return 8'h02;
        return 8'h00;
    endfunction

    function automatic bit is_ignored(input int ofs);
        return ofs == 'h0D || ofs == 'h0E || (ofs >= 'h18 && ofs <= 'h1B) ||
               ofs == 'h3A || ofs == 'h3E || ofs == 'h3F || ofs == 'h42 ||
               ofs == 'h43 || ofs == 'h46 || ofs == 'h47;
    endfunction

    function automatic logic [7:0] after_write(input int ofs, input logic [7:0] old,
                                               input logic [7:0] v);
        if (ofs >= STORE)                  return 8'h00;
        if (is_ignored(ofs))               return old;
        if (ofs == 'h0C)                   return old & ~(v & 8'h7F);
        if (ofs == 'h0F)                   return old & ~(v & 8'h40);
        if (ofs == 'h39 || ofs == 'h41)    return v & 8'h3F;
        if (ofs == 'h3B)                   return v & 8'h80;
        if (ofs == 'h45)                   return v & 8'h0F;
        return v;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input int ofs, input logic [7:0] v);
        @(negedge clk);
        addr    = 12'(ofs);
        wr_data = v;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic rd(input int ofs, output logic [7:0] v);
        addr = 12'(ofs);
        #1;
        v = rd_data;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        do_reset();

        // R1: power-up image across the whole offset space
        for (int o = 0; o < 4096; o++) begin
            rd(o, v);
            check("R1 reset image", v, dflt(o));
        end
        check("R6 smi idle after reset", {7'd0, smi_pulse}, 8'h00);
        check("R10 strobe idle after reset", {7'd0, port_chg_strobe}, 8'h00);

        // R3 R7 R8 R9: write sweep over stored lanes, skipping command lanes
        for (int o = 0; o < STORE; o++) begin
            logic [7:0] pat;
            if (o == 'h04 || o == 'h08) continue;
            pat = 8'((o * 53 + 11) ^ 8'hA5);
            wr(o, pat);
            rd(o, v);
            check("R3/R7/R8/R9 lane after write", v, after_write(o, dflt(o), pat));
        end

        // R2: beyond storage
        wr('h200, 8'hA5);
        rd('h200, v);
        check("R2 beyond store", v, 8'h00);
        wr('hFFF, 8'h3C);
        rd('hFFF, v);
        check("R2 top offset", v, 8'h00);
        rd('h7F, v);
        check("R2 no alias into store", v, after_write('h7F, 0, 8'((127 * 53 + 11) ^ 8'hA5)));

        // R5 / R6: ownership flag with interrupt disabled
        do_reset();
        wr('h08, 8'h08);
        check("R6 no smi when disabled", {7'd0, smi_pulse}, 8'h00);
        rd('h0F, v);
        check("R5 ownership flag", v, 8'h40);
        rd('h08, v);
        check("R5 cmd byte stored", v, 8'h08);
        // R7: 0x0F clears only bit 6
        wr('h0F, 8'hBF);
        rd('h0F, v);
        check("R7 0x0F other bits no clear", v, 8'h40);
        wr('h0F, 8'h40);
        rd('h0F, v);
        check("R7 0x0F bit6 cleared", v, 8'h00);
        // R6: only one enable bit
        wr('h13, 8'h80);
        wr('h08, 8'h08);
        check("R6 single enable no smi", {7'd0, smi_pulse}, 8'h00);
        wr('h13, 8'h40);
        wr('h08, 8'h08);
        check("R6 other enable no smi", {7'd0, smi_pulse}, 8'h00);
        // R6: both enables
        wr('h13, 8'hC0);
        wr('h08, 8'h08);
        check("R6 smi pulse", {7'd0, smi_pulse}, 8'h01);
        @(negedge clk);
        check("R6 smi one cycle", {7'd0, smi_pulse}, 8'h00);
        wr('h08, 8'h02);
        check("R6 no smi without request", {7'd0, smi_pulse}, 8'h00);

        // R4: soft reset overrides ownership, strips bit 0
        wr('h20, 8'h77);
        wr('h48, 8'h99);
        wr('h00, 8'h55);
        wr('h08, 8'h09);
        check("R6 smi with reset+request", {7'd0, smi_pulse}, 8'h01);
        rd('h0F, v);
        check("R4 reset beats ownership", v, 8'h00);
        rd('h08, v);
        check("R4 cmd byte bit0 stripped", v, 8'h08);
        rd('h20, v);
        check("R4 plain lane defaulted", v, 8'h00);
        rd('h48, v);
        check("R4 lane 0x48 default", v, 8'h02);
        rd('h00, v);
        check("R4 lane 0x00 default", v, 8'h10);
        rd('h13, v);
        check("R4 enable cleared", v, 8'h00);

        // R10: control byte
        wr('h56, 8'h01);
        wr('h5A, 8'h02);
        wr('h04, 8'h80);
        check("R10 no strobe on 0x80", {7'd0, port_chg_strobe}, 8'h00);
        rd('h56, v);
        check("R10 port1 untouched", v, 8'h01);
        wr('h04, 8'hC3);
        check("R10 no strobe on 0xC3", {7'd0, port_chg_strobe}, 8'h00);
        rd('h5A, v);
        check("R10 port2 untouched", v, 8'h02);
        wr('h04, 8'h3F);
        check("R10 strobe", {7'd0, port_chg_strobe}, 8'h01);
        rd('h56, v);
        check("R10 port1 loaded", v, 8'h16);
        rd('h5A, v);
        check("R10 port2 loaded", v, 8'h16);
        rd('h04, v);
        check("R10 ctrl stored", v, 8'h3F);
        @(negedge clk);
        check("R10 strobe one cycle", {7'd0, port_chg_strobe}, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule